// File: doc/BRIEF.md
# ALU with Condition Status Register

This block pairs an 8-bit arithmetic/logic unit with the 8-bit status register that holds a processor's condition flags. Each cycle the unit combines two operands under a 4-bit operation code and produces a result combinationally. When `op_valid_i` is high, the flags touched by that operation are stored in the status register on the next rising clock edge.

Besides carry, zero, negative and overflow, the register derives a sign flag and a half-carry flag. It also holds a one-bit transfer store used by bit-copy operations and the global interrupt-enable bit, which drives `irq_en_o`. Software reaches the whole register through a memory-mapped port at data address 0x5F. Single operations set or clear any one of its bits.

Top module: `alu_flags_unit`

## Requirements
- R1: While reset is low, and after it is released, the status register reads 0x00 and `irq_en_o` is 0.
- R2: The register bits are fixed: bit 7 is the interrupt enable (also driven on `irq_en_o`), bit 6 the transfer bit T, bit 5 half-carry H, bit 4 sign S, bit 3 overflow V, bit 2 negative N, bit 1 zero Z, bit 0 carry C.
- R3: Add (op 0x0) gives A+B and add-with-carry (op 0x1) gives A+B+C. C takes the carry out of bit 7, H the carry out of bit 3, and V is set when both operands share a sign that the result lacks.
- R4: Subtract (op 0x2) gives A-B and subtract-with-carry (op 0x3) gives A-B-C. C and H flag a borrow out of bit 7 and out of bit 3. V = (A7 & ~B7 & ~R7) | (~A7 & B7 & R7).
- R5: Every arithmetic or logic operation sets Z exactly when the 8-bit result is zero and copies result bit 7 into N.
- R6: After any arithmetic or logic update, S equals N xor V.
- R7: AND (op 0x4), OR (op 0x5) and XOR (op 0x6) clear V and leave C, H, T and I unchanged.
- R8: Bit-store (op 0x7) copies A[bit_sel_i] into T. Bit-load (op 0x8) outputs A with bit bit_sel_i replaced by T and changes no flag.
- R9: Flag-set (op 0x9) sets, and flag-clear (op 0xA), clears status bit bit_sel_i; other bits are kept.
- R10: The port returns the register when `io_addr_i` is 0x5F and 0x00 at any other address. A write at 0x5F replaces all eight bits, and writes at other addresses leave the register unchanged.
- R11: A port write at 0x5F in the same cycle as a valid operation wins: the register takes the written value.
- R12: With `op_valid_i` low and no port write, the register holds its value. Arithmetic operations never alter T or I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Commit the flags of the current operation |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| bit_sel_i | input | 3 | Bit index for bit-copy, set and clear operations |
| result_o | output | 8 | Combinational result |
| io_we_i | input | 1 | Port write strobe |
| io_addr_i | input | 16 | Port data address |
| io_wdata_i | input | 8 | Port write data |
| io_rdata_o | output | 8 | Port read data |
| sreg_o | output | 8 | Status register contents |
| irq_en_o | output | 1 | Global interrupt enable |

## Verification
The properties assume that every input is known at each rising edge while reset is high, and that `bit_sel_i` indexes a real bit. The flag rules are checked only when no port write to 0x5F lands in the same cycle, since that write replaces the register. The stimulus changes inputs only on falling edges and pulses `op_valid_i` for a single cycle. It combines an operation with a port write only in the test of the override rule. Operand patterns come from a fixed-seed shift register, so the carry, borrow and overflow cases recur in every run.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int unsigned SREG_W = 8;

  // status register bit positions
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_N = 2;
  localparam int unsigned FL_V = 3;
  localparam int unsigned FL_S = 4;
  localparam int unsigned FL_H = 5;
  localparam int unsigned FL_T = 6;
  localparam int unsigned FL_I = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADC  = 4'h1,
    OP_SUB  = 4'h2,
    OP_SBC  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_BST  = 4'h7,
    OP_BLD  = 4'h8,
    OP_BSET = 4'h9,
    OP_BCLR = 4'hA
  } alu_op_e;

  // logic unit function select, taken from op_i[1:0]
  localparam logic [1:0] LF_AND = 2'b00;
  localparam logic [1:0] LF_OR  = 2'b01;
  localparam logic [1:0] LF_XOR = 2'b10;

endpackage

// File: rtl/alu_flags_arith.sv
module alu_flags_arith #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              use_c_i,
  input  logic              c_flag_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned MSB  = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_in;
  logic              cy_half;
  logic              cy_top;

  assign b_eff = sub_i ? ~b_i : b_i;
  // subtraction adds the inverted operand; an incoming borrow removes the +1
  assign c_in  = sub_i ? ~(use_c_i & c_flag_i) : (use_c_i & c_flag_i);

  always_comb begin
    logic cy;
    cy      = c_in;
    cy_half = 1'b0;
    sum_o   = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      sum_o[i] = a_i[i] ^ b_eff[i] ^ cy;
      cy       = (a_i[i] & b_eff[i]) | (a_i[i] & cy) | (b_eff[i] & cy);
      if (i == int'(HALF) - 1) cy_half = cy;
    end
    cy_top = cy;
  end

  // borrow is the inverse of carry for subtraction
  assign c_o = sub_i ? ~cy_top  : cy_top;
  assign h_o = sub_i ? ~cy_half : cy_half;
  assign v_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_flags_logic.sv
module alu_flags_logic
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    always_comb begin
      unique case (fn_i)
        LF_AND:  res_o[g] = a_i[g] & b_i[g];
        LF_OR:   res_o[g] = a_i[g] | b_i[g];
        LF_XOR:  res_o[g] = a_i[g] ^ b_i[g];
        default: res_o[g] = a_i[g];
      endcase
    end
  end

endmodule

// File: rtl/alu_flags_bitops.sv
module alu_flags_bitops #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              t_i,
  output logic [DATA_W-1:0] ld_o,
  output logic              st_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign ld_o[g] = (sel_i == SEL_W'(g)) ? t_i : a_i[g];
  end

  assign st_o = a_i[sel_i];

endmodule

// File: rtl/alu_flags_sreg.sv
module alu_flags_sreg
  import alu_flags_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SREG_ADDR = 'h5F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [SREG_W-1:0] mask_i,
  input  logic [SREG_W-1:0] flags_i,
  input  logic              io_we_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [SREG_W-1:0] io_wdata_i,
  output logic [SREG_W-1:0] io_rdata_o,
  output logic [SREG_W-1:0] sreg_o
);
  logic [SREG_W-1:0] sreg_q;
  logic              addr_hit;
  logic              wr_hit;

  assign addr_hit = (io_addr_i == ADDR_W'(SREG_ADDR));
  assign wr_hit   = io_we_i && addr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (wr_hit) sreg_q <= io_wdata_i;
    else if (upd_i)  sreg_q <= (sreg_q & ~mask_i) | (flags_i & mask_i);
  end

  assign sreg_o     = sreg_q;
  assign io_rdata_o = addr_hit ? sreg_q : '0;

  a_r11_io_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> sreg_q == $past(io_wdata_i));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_hit) |=> $stable(sreg_q));

  a_r10_foreign_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hit |-> io_rdata_o == '0);

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SREG_ADDR = 'h5F,
  localparam int unsigned SEL_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  output logic [DATA_W-1:0] result_o,
  input  logic              io_we_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [SREG_W-1:0] io_wdata_i,
  output logic [SREG_W-1:0] io_rdata_o,
  output logic [SREG_W-1:0] sreg_o,
  output logic              irq_en_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [SREG_W-1:0] ARITH_MASK =
    SREG_W'((1 << FL_C) | (1 << FL_Z) | (1 << FL_N) | (1 << FL_V) | (1 << FL_S) | (1 << FL_H));
  localparam logic [SREG_W-1:0] LOGIC_MASK =
    SREG_W'((1 << FL_Z) | (1 << FL_N) | (1 << FL_V) | (1 << FL_S));

  logic [DATA_W-1:0] sum_w, lres_w, ld_w;
  logic              cf_w, hf_w, vf_w, st_w;
  logic              is_sub, use_c, is_arith, is_logic;
  logic [SREG_W-1:0] mask_w, nf_w;
  logic              io_hit;

  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    is_sub   = 1'b0;
    use_c    = 1'b0;
    case (op_i)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; use_c = 1'b1; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBC: begin is_arith = 1'b1; is_sub = 1'b1; use_c = 1'b1; end
      OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
      default: ;
    endcase
  end

  alu_flags_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (is_sub),
    .use_c_i  (use_c),
    .c_flag_i (sreg_o[FL_C]),
    .sum_o    (sum_w),
    .c_o      (cf_w),
    .h_o      (hf_w),
    .v_o      (vf_w)
  );

  alu_flags_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (op_i[1:0]),
    .res_o(lres_w)
  );

  alu_flags_bitops #(.DATA_W(DATA_W)) u_bitops (
    .a_i  (a_i),
    .sel_i(bit_sel_i),
    .t_i  (sreg_o[FL_T]),
    .ld_o (ld_w),
    .st_o (st_w)
  );

  always_comb begin
    result_o = a_i;
    mask_w   = '0;
    nf_w     = '0;
    if (is_arith) begin
      result_o   = sum_w;
      mask_w     = ARITH_MASK;
      nf_w[FL_C] = cf_w;
      nf_w[FL_H] = hf_w;
      nf_w[FL_V] = vf_w;
      nf_w[FL_N] = sum_w[MSB];
      nf_w[FL_Z] = (sum_w == '0);
      nf_w[FL_S] = sum_w[MSB] ^ vf_w;
    end else if (is_logic) begin
      result_o   = lres_w;
      mask_w     = LOGIC_MASK;
      nf_w[FL_N] = lres_w[MSB];
      nf_w[FL_Z] = (lres_w == '0);
      nf_w[FL_S] = lres_w[MSB];
    end else begin
      case (op_i)
        OP_BST: begin
          mask_w[FL_T] = 1'b1;
          nf_w[FL_T]   = st_w;
        end
        OP_BLD:  result_o = ld_w;
        OP_BSET: begin
          mask_w = SREG_W'(1) << bit_sel_i;
          nf_w   = '1;
        end
        OP_BCLR: mask_w = SREG_W'(1) << bit_sel_i;
        default: ;
      endcase
    end
  end

  alu_flags_sreg #(.ADDR_W(ADDR_W), .SREG_ADDR(SREG_ADDR)) u_sreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (op_valid_i),
    .mask_i    (mask_w),
    .flags_i   (nf_w),
    .io_we_i   (io_we_i),
    .io_addr_i (io_addr_i),
    .io_wdata_i(io_wdata_i),
    .io_rdata_o(io_rdata_o),
    .sreg_o    (sreg_o)
  );

  assign irq_en_o = sreg_o[FL_I];

  assign io_hit = io_we_i && (io_addr_i == ADDR_W'(SREG_ADDR));

  a_r6_sign_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (is_arith || is_logic) && !io_hit)
      |=> sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V]));

  a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (is_arith || is_logic) && !io_hit)
      |=> sreg_o[FL_Z] == ($past(result_o) == '0));

  a_r7_logic_keeps_ch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && is_logic && !io_hit)
      |=> $stable(sreg_o[FL_C]) && $stable(sreg_o[FL_H]) && !sreg_o[FL_V]);

  a_r12_arith_keeps_ti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && is_arith && !io_hit)
      |=> $stable(sreg_o[FL_T]) && $stable(sreg_o[FL_I]));

  a_r8_bld_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_BLD && !io_hit) |=> $stable(sreg_o));

  a_r9_bset_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_BSET && !io_hit) |=> sreg_o[$past(bit_sel_i)]);

  a_r9_bclr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_BCLR && !io_hit) |=> !sreg_o[$past(bit_sel_i)]);

endmodule

// File: tb/sim_alu_flags_unit.sv
`timescale 1ns/1ps
module sim_alu_flags_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op;
  logic [7:0]  a, b;
  logic [2:0]  sel;
  logic [7:0]  result;
  logic        io_we;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [7:0]  sreg;
  logic        irq_en;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  msreg;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  alu_flags_unit u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_valid_i(op_valid),
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .bit_sel_i (sel),
    .result_o  (result),
    .io_we_i   (io_we),
    .io_addr_i (io_addr),
    .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata),
    .sreg_o    (sreg),
    .irq_en_o  (irq_en)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd8();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  // reference model built from the requirements; updates msreg
  task automatic model_op(input logic [3:0] o, input logic [7:0] ma, input logic [7:0] mb,
                          input logic [2:0] ms, output logic [7:0] r);
    int t, cin;
    logic c, h, v;
    r = ma;
    case (o)
      4'h0, 4'h1: begin
        cin = (o == 4'h1) ? int'(msreg[0]) : 0;
        t = int'(ma) + int'(mb) + cin;
        r = t[7:0];
        c = (t > 255);
        h = ((int'(ma) % 16) + (int'(mb) % 16) + cin) > 15;
        v = (ma[7] == mb[7]) && (r[7] != ma[7]);
        msreg[0] = c; msreg[1] = (r == 8'h00); msreg[2] = r[7];
        msreg[3] = v; msreg[4] = r[7] ^ v; msreg[5] = h;
      end
      4'h2, 4'h3: begin
        cin = (o == 4'h3) ? int'(msreg[0]) : 0;
        t = int'(ma) - int'(mb) - cin;
        r = t[7:0];
        c = int'(ma) < int'(mb) + cin;
        h = (int'(ma) % 16) < (int'(mb) % 16) + cin;
        v = (ma[7] && !mb[7] && !r[7]) || (!ma[7] && mb[7] && r[7]);
        msreg[0] = c; msreg[1] = (r == 8'h00); msreg[2] = r[7];
        msreg[3] = v; msreg[4] = r[7] ^ v; msreg[5] = h;
      end
      4'h4, 4'h5, 4'h6: begin
        r = (o == 4'h4) ? (ma & mb) : (o == 4'h5) ? (ma | mb) : (ma ^ mb);
        msreg[1] = (r == 8'h00); msreg[2] = r[7]; msreg[3] = 1'b0; msreg[4] = r[7];
      end
      4'h7: msreg[6] = ma[ms];
      4'h8: r[ms] = msreg[6];
      4'h9: msreg[ms] = 1'b1;
      4'hA: msreg[ms] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic do_op(input string tag, input logic [3:0] o, input logic [7:0] oa,
                       input logic [7:0] ob, input logic [2:0] os);
    logic [7:0] r;
    @(negedge clk);
    op = o; a = oa; b = ob; sel = os; op_valid = 1'b1;
    #1;
    model_op(o, oa, ob, os, r);
    chk8({tag, " result"}, result, r);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    chk8({tag, " sreg"}, sreg, msreg);
  endtask

  task automatic io_write(input logic [15:0] ad, input logic [7:0] d);
    @(negedge clk);
    io_we = 1'b1; io_addr = ad; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
    if (ad == 16'h005F) msreg = d;
  endtask

  task automatic io_read(input string tag, input logic [15:0] ad, input logic [7:0] exp);
    @(negedge clk);
    io_addr = ad;
    #1;
    chk8(tag, io_rdata, exp);
  endtask

  task automatic t_reset();
    #1;
    chk8("R1 sreg in reset", sreg, 8'h00);
    chk8("R1 irq_en in reset", {7'd0, irq_en}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    io_read("R1 read after reset", 16'h005F, 8'h00);
  endtask

  task automatic t_add();
    io_write(16'h005F, 8'h00);
    do_op("R3 add 7F+01", 4'h0, 8'h7F, 8'h01, 3'd0);
    chk8("R3 R6 flags 7F+01", sreg, 8'h2C);
    do_op("R5 add FF+01", 4'h0, 8'hFF, 8'h01, 3'd0);
    chk8("R5 zero carry flags", sreg, 8'h23);
    do_op("R3 adc 10+20+C", 4'h1, 8'h10, 8'h20, 3'd0);
    chk8("R3 adc result flags", sreg, 8'h00);
  endtask

  task automatic t_sub();
    do_op("R4 sub 80-01", 4'h2, 8'h80, 8'h01, 3'd0);
    chk8("R4 R6 flags 80-01", sreg, 8'h38);
    do_op("R4 sub 00-01", 4'h2, 8'h00, 8'h01, 3'd0);
    chk8("R4 borrow flags", sreg, 8'h35);
    do_op("R4 sbc 05-04-C", 4'h3, 8'h05, 8'h04, 3'd0);
    chk8("R4 sbc zero flags", sreg, 8'h02);
  endtask

  task automatic t_logic();
    io_write(16'h005F, 8'hE1 | 8'h20);
    do_op("R7 and F0&0F", 4'h4, 8'hF0, 8'h0F, 3'd0);
    chk8("R7 and keeps C H T I", sreg, 8'hE3);
    io_write(16'h005F, 8'h29);
    do_op("R7 or 80|01", 4'h5, 8'h80, 8'h01, 3'd0);
    chk8("R7 or clears V", sreg, 8'h35);
    do_op("R7 xor 5A^5A", 4'h6, 8'h5A, 8'h5A, 3'd0);
  endtask

  task automatic t_bits();
    io_write(16'h005F, 8'h00);
    do_op("R8 bst bit6=1", 4'h7, 8'h40, 8'h00, 3'd6);
    chk8("R8 T set", sreg, 8'h40);
    do_op("R8 bld bit3", 4'h8, 8'h00, 8'h00, 3'd3);
    chk8("R8 bld result", result, 8'h08);
    do_op("R8 bst bit6=0", 4'h7, 8'hBF, 8'h00, 3'd6);
    do_op("R8 bld clears bit", 4'h8, 8'hFF, 8'h00, 3'd0);
  endtask

  task automatic t_setclr();
    do_op("R9 bset I", 4'h9, 8'h00, 8'h00, 3'd7);
    chk8("R2 R9 irq_en high", {7'd0, irq_en}, 8'h01);
    do_op("R9 bset V", 4'h9, 8'h00, 8'h00, 3'd3);
    chk8("R2 R9 V at bit 3", sreg, 8'h88);
    do_op("R9 bclr I", 4'hA, 8'h00, 8'h00, 3'd7);
    chk8("R2 R9 irq_en low", {7'd0, irq_en}, 8'h00);
  endtask

  task automatic t_io();
    io_write(16'h005F, 8'hA5);
    io_read("R10 read back", 16'h005F, 8'hA5);
    chk8("R2 irq_en from bit 7", {7'd0, irq_en}, 8'h01);
    io_write(16'h005E, 8'h00);
    io_read("R10 other address read", 16'h005E, 8'h00);
    chk8("R10 other address write ignored", sreg, 8'hA5);
  endtask

  task automatic t_override();
    @(negedge clk);
    op = 4'h0; a = 8'h7F; b = 8'h01; sel = 3'd0; op_valid = 1'b1;
    io_we = 1'b1; io_addr = 16'h005F; io_wdata = 8'h5A;
    @(negedge clk);
    op_valid = 1'b0; io_we = 1'b0;
    #1;
    msreg = 8'h5A;
    chk8("R11 port write wins", sreg, 8'h5A);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op = 4'h0; a = 8'hFF; b = 8'h01; op_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk8("R12 idle hold", sreg, msreg);
    io_write(16'h005F, 8'hC0);
    do_op("R12 add keeps T I", 4'h0, 8'h01, 8'h01, 3'd0);
    chk8("R12 T I kept", sreg & 8'hC0, 8'hC0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 60; i++) begin
      logic [3:0] o;
      o = rnd8() % 8'd11;
      do_op("R3 R4 R5 R6 R7 R8 sweep", o, rnd8(), rnd8(), rnd8() % 8'd8);
    end
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op = '0; a = '0; b = '0; sel = '0;
    io_we = 1'b0; io_addr = '0; io_wdata = '0; msreg = 8'h00;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_bits();
    t_setclr();
    t_io();
    t_override();
    t_idle();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule